// File: doc/BRIEF.md
# UART Interrupt Aggregator with Modem Loopback

This block keeps the interrupt state of a serial port. It holds an eleven-bit raw status word and a mask. Software reads the raw word, the masked word and the mask through a small register port, and clears raw bits with a write-one-to-clear register. Six interrupt lines leave the block. Line 0 is the OR of every masked source. Lines 1 to 5 each carry one source group after masking. Receive-trigger, receive-timeout and line-error events arrive as single-cycle strobes, and any write to the data register raises the transmit bit.

The block also provides internal loopback. When the loopback bit of the control register is set, the four modem control outputs held in that register are copied into the modem status flags in the same cycle that the control write lands. The whole modem interrupt group is rewritten from those flags. In this mode, transmitted bytes and send-break assertions go straight to the receive queue, and characters from the external receiver are dropped. When loopback is off, external characters pass through to the receive queue.

Top module: `uart_irq_lb`

## Requirements
- R1: A read of select 4 returns the raw status, select 5 returns raw AND mask, select 3 returns the mask, and select 6 (clear) and select 0 (data) read as zero. Select 1 returns the control register and select 2 returns the break bit in bit 0.
- R2: A write to select 6 clears each raw bit whose written bit is 1. A set event in the same cycle wins over the clear.
- R3: The raw layout is RI=0, CTS=1, DCD=2, DSR=3, RX=4, TX=5, RT=6, FE=7, PE=8, BE=9, OE=10. irq_o[0] is the OR of all masked bits. irq_o[1..5] carry masked RX, TX, RT, the OR of masked bits 0-3, and the OR of masked bits 7-10.
- R4: Any write to select 0 (data) sets TX in the next cycle.
- R5: rx_trig_set sets RX and rx_trig_clr clears it, with set winning if both strobe. rt_set sets RT, and err_set[3:0] sets bits 7 to 10.
- R6: Control bits are loopback=0, DTR=1, RTS=2, Out1=3, Out2=4. A control write whose new loopback bit is 1 loads the flags (select 7: RI=0, CTS=1, DCD=2, DSR=3) with RI=Out2, CTS=RTS, DCD=Out1, DSR=DTR, in that same cycle. This holds even when loopback was off before the write. A control write with loopback 0 leaves the flags unchanged.
- R7: On such a loopback update, raw bits 0 to 3 are replaced by the new flags. Modem bits that were set before the update and whose flag is now 0 are cleared.
- R8: With loopback on, a data write pushes {0, wr_data[7:0]} on rxq_data[8:0]. A write to select 2 that raises the break bit from 0 pushes {1, 8'h00}. ext_rx_valid is ignored. With loopback off, ext_rx_valid pushes {0, ext_rx_data} and data writes push nothing.
- R9: Writes to selects 4, 5 and 7 change nothing. Reset clears the mask, the raw status, the control register, the break bit and the flags.
- R10: The irq_o lines, rd_data and the receive push follow their inputs and state combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | REG_W | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | REG_W | Read data |
| rx_trig_set | input | 1 | Receive trigger reached |
| rx_trig_clr | input | 1 | Receive level dropped below trigger |
| rt_set | input | 1 | Receive timeout event |
| err_set | input | 4 | Framing, parity, break and overrun events |
| ext_rx_valid | input | 1 | External receiver character strobe |
| ext_rx_data | input | 8 | External receiver character |
| rxq_push | output | 1 | Push into receive queue |
| rxq_data | output | 9 | Pushed entry: bit 8 break, bits 7:0 byte |
| irq_o | output | 6 | Combined line and five per-group lines |

## Verification
The assertions assume that the event strobes are single-cycle pulses that need no handshake, and that at most one register write happens per cycle. The interface allows no more than one write per cycle. The clear and no-effect properties are guarded so that they only fire in cycles without a competing set event or loopback update. The random stimulus hits all eight selects and the event strobes at high rates, so it exercises those guards from both sides. Directed sequences then pin down the loopback entry, break pushes and full clears.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int RAW_W   = 11;
  localparam int NLINES  = 6;
  localparam int CTRL_W  = 5;
  localparam int MODEM_W = 4;

  // raw status bit positions
  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RT  = 6;
  localparam int B_FE  = 7;

  // control register bit positions
  localparam int C_LB   = 0;
  localparam int C_DTR  = 1;
  localparam int C_RTS  = 2;
  localparam int C_OUT1 = 3;
  localparam int C_OUT2 = 4;

  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_LINE = 3'd2,
    SEL_MASK = 3'd3,
    SEL_RAW  = 3'd4,
    SEL_MSKD = 3'd5,
    SEL_CLR  = 3'd6,
    SEL_FLAG = 3'd7
  } reg_sel_e;

  // which raw bits feed each output line
  function automatic logic [RAW_W-1:0] line_group(input int idx);
    logic [RAW_W-1:0] g;
    g = '0;
    case (idx)
      0: g = '1;
      1: g[B_RX] = 1'b1;
      2: g[B_TX] = 1'b1;
      3: g[B_RT] = 1'b1;
      4: g[MODEM_W-1:0] = '1;
      default: g[RAW_W-1:B_FE] = '1;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic             brk_q,
  output logic [RAW_W-1:0] mask_q,
  output logic             lb_upd,
  output logic             brk_rise
);
  logic             ctrl_we, line_we, mask_we;
  logic [CTRL_W-1:0] ctrl_d;
  logic             brk_d;
  logic [RAW_W-1:0] mask_d;

  always_comb begin
    ctrl_we  = wr_en && (wr_sel == SEL_CTRL);
    line_we  = wr_en && (wr_sel == SEL_LINE);
    mask_we  = wr_en && (wr_sel == SEL_MASK);
    ctrl_d   = ctrl_we ? wr_data[CTRL_W-1:0] : ctrl_q;
    brk_d    = line_we ? wr_data[0] : brk_q;
    mask_d   = mask_we ? wr_data[RAW_W-1:0] : mask_q;
    lb_upd   = ctrl_we && wr_data[C_LB];
    brk_rise = line_we && wr_data[0] && !brk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      brk_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (line_we) brk_q  <= brk_d;
      if (mask_we) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lb_upd,
  input  logic [REG_W-1:0]   wr_data,
  output logic [MODEM_W-1:0] flags_q,
  output logic [MODEM_W-1:0] flags_new
);
  logic [MODEM_W-1:0] flags_d;

  always_comb begin
    flags_new        = '0;
    flags_new[B_RI]  = wr_data[C_OUT2];
    flags_new[B_CTS] = wr_data[C_RTS];
    flags_new[B_DCD] = wr_data[C_OUT1];
    flags_new[B_DSR] = wr_data[C_DTR];
    flags_d          = lb_upd ? flags_new : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (lb_upd) flags_q <= flags_d;
  end
endmodule

// File: rtl/uart_irq_raw.sv
module uart_irq_raw
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rx_trig_set,
  input  logic               rx_trig_clr,
  input  logic               rt_set,
  input  logic [3:0]         err_set,
  input  logic               lb_upd,
  input  logic [MODEM_W-1:0] flags_new,
  output logic [RAW_W-1:0]   raw_q
);
  logic [RAW_W-1:0] raw_d;
  logic             raw_en;

  always_comb begin
    raw_d = raw_q;
    if (wr_en && (wr_sel == SEL_CLR)) raw_d = raw_d & ~wr_data[RAW_W-1:0];
    if (rx_trig_set)      raw_d[B_RX] = 1'b1;
    else if (rx_trig_clr) raw_d[B_RX] = 1'b0;
    if (wr_en && (wr_sel == SEL_DATA)) raw_d[B_TX] = 1'b1;
    if (rt_set) raw_d[B_RT] = 1'b1;
    raw_d[RAW_W-1:B_FE] = raw_d[RAW_W-1:B_FE] | err_set;
    if (lb_upd) raw_d[MODEM_W-1:0] = flags_new;
    raw_en = (raw_d != raw_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
  import uart_irq_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_q,
  input  logic [RAW_W-1:0]  mask_q,
  output logic [NLINES-1:0] irq_o
);
  logic [RAW_W-1:0] masked;
  assign masked = raw_q & mask_q;

  for (genvar li = 0; li < NLINES; li++) begin : g_line
    localparam logic [RAW_W-1:0] GRP = line_group(li);
    assign irq_o[li] = |(masked & GRP);
  end
endmodule

// File: rtl/uart_irq_lb.sv
module uart_irq_lb
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             rx_trig_set,
  input  logic             rx_trig_clr,
  input  logic             rt_set,
  input  logic [3:0]       err_set,
  input  logic             ext_rx_valid,
  input  logic [7:0]       ext_rx_data,
  output logic             rxq_push,
  output logic [8:0]       rxq_data,
  output logic [5:0]       irq_o
);
  logic               rst_n_s;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               brk_q;
  logic [RAW_W-1:0]   mask_q;
  logic               lb_upd;
  logic               brk_rise;
  logic [MODEM_W-1:0] flags_q;
  logic [MODEM_W-1:0] flags_new;
  logic [RAW_W-1:0]   raw_q;
  logic               lb_on;

  uart_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  uart_irq_cfg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .brk_q(brk_q), .mask_q(mask_q),
    .lb_upd(lb_upd), .brk_rise(brk_rise)
  );

  uart_irq_modem #(.REG_W(REG_W)) u_modem (
    .clk(clk), .rst_n(rst_n_s), .lb_upd(lb_upd), .wr_data(wr_data),
    .flags_q(flags_q), .flags_new(flags_new)
  );

  uart_irq_raw #(.REG_W(REG_W)) u_raw (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rx_trig_set(rx_trig_set), .rx_trig_clr(rx_trig_clr),
    .rt_set(rt_set), .err_set(err_set), .lb_upd(lb_upd),
    .flags_new(flags_new), .raw_q(raw_q)
  );

  uart_irq_lines u_lines (
    .raw_q(raw_q), .mask_q(mask_q), .irq_o(irq_o)
  );

  assign lb_on = ctrl_q[C_LB];

  // receive queue source select
  always_comb begin
    rxq_push = 1'b0;
    rxq_data = '0;
    if (lb_on && wr_en && (wr_sel == SEL_DATA)) begin
      rxq_push = 1'b1;
      rxq_data = {1'b0, wr_data[7:0]};
    end else if (lb_on && brk_rise) begin
      rxq_push = 1'b1;
      rxq_data = {1'b1, 8'h00};
    end else if (!lb_on && ext_rx_valid) begin
      rxq_push = 1'b1;
      rxq_data = {1'b0, ext_rx_data};
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_CTRL: rd_data[CTRL_W-1:0]  = ctrl_q;
      SEL_LINE: rd_data[0]           = brk_q;
      SEL_MASK: rd_data[RAW_W-1:0]   = mask_q;
      SEL_RAW:  rd_data[RAW_W-1:0]   = raw_q;
      SEL_MSKD: rd_data[RAW_W-1:0]   = raw_q & mask_q;
      SEL_FLAG: rd_data[MODEM_W-1:0] = flags_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_lb_chk.sv
module uart_irq_lb_chk
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               wr_en,
  input logic [2:0]         wr_sel,
  input logic [REG_W-1:0]   wr_data,
  input logic               rx_trig_set,
  input logic               rt_set,
  input logic [3:0]         err_set,
  input logic               ext_rx_valid,
  input logic [CTRL_W-1:0]  ctrl_q,
  input logic [MODEM_W-1:0] flags_q,
  input logic [RAW_W-1:0]   raw_q,
  input logic               rxq_push,
  input logic [5:0]         irq_o
);
  // R2
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_CLR && !rx_trig_set && !rt_set && err_set == 4'd0)
    |=> ((raw_q & $past(wr_data[RAW_W-1:0])) == '0));

  // R3
  combined_line_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o[0] == (|irq_o[5:1]));

  // R4
  tx_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_DATA) |=> raw_q[B_TX]);

  // R6
  loop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_CTRL && wr_data[C_LB])
    |=> (flags_q == {$past(wr_data[C_DTR]), $past(wr_data[C_OUT1]),
                     $past(wr_data[C_RTS]), $past(wr_data[C_OUT2])}));

  // R7
  loop_group_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_CTRL && wr_data[C_LB]) |=> (raw_q[MODEM_W-1:0] == flags_q));

  // R8
  ext_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_q[C_LB] && ext_rx_valid && !wr_en) |-> !rxq_push);

  // R9
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_FLAG) |=> $stable(flags_q));
endmodule

bind uart_irq_lb uart_irq_lb_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rx_trig_set(rx_trig_set), .rt_set(rt_set),
  .err_set(err_set), .ext_rx_valid(ext_rx_valid), .ctrl_q(ctrl_q),
  .flags_q(flags_q), .raw_q(raw_q), .rxq_push(rxq_push), .irq_o(irq_o)
);

// File: tb/uart_irq_lb_bench.sv
module uart_irq_lb_bench;
  localparam int REG_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [2:0]       wr_sel;
  logic [REG_W-1:0] wr_data;
  logic [2:0]       rd_sel;
  logic [REG_W-1:0] rd_data;
  logic             rx_trig_set, rx_trig_clr, rt_set;
  logic [3:0]       err_set;
  logic             ext_rx_valid;
  logic [7:0]       ext_rx_data;
  logic             rxq_push;
  logic [8:0]       rxq_data;
  logic [5:0]       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  logic [10:0] m_raw, m_mask;
  logic [4:0]  m_ctrl;
  logic        m_brk;
  logic [3:0]  m_flags;

  always #4 clk = ~clk;

  uart_irq_lb #(.REG_W(REG_W)) u_uart_irq_lb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .rx_trig_set(rx_trig_set), .rx_trig_clr(rx_trig_clr), .rt_set(rt_set),
    .err_set(err_set), .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data),
    .rxq_push(rxq_push), .rxq_data(rxq_data), .irq_o(irq_o)
  );

  function automatic logic [5:0] exp_lines(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] x;
    x = r & m;
    return {|x[10:7], |x[3:0], x[6], x[5], x[4], |x};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] s);
    case (s)
      3'd1: return {11'd0, m_ctrl};
      3'd2: return {15'd0, m_brk};
      3'd3: return {5'd0, m_mask};
      3'd4: return {5'd0, m_raw};
      3'd5: return {5'd0, m_raw & m_mask};
      3'd7: return {12'd0, m_flags};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                      input logic [2:0] rs, input logic rset, input logic rclr,
                      input logic rt, input logic [3:0] es, input logic ev,
                      input logic [7:0] ed);
    logic       e_push;
    logic [8:0] e_dat;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    rx_trig_set = rset; rx_trig_clr = rclr; rt_set = rt; err_set = es;
    ext_rx_valid = ev; ext_rx_data = ed;
    #1;
    e_push = 1'b0; e_dat = '0;
    if (m_ctrl[0] && we && ws == 3'd0) begin e_push = 1; e_dat = {1'b0, wd[7:0]}; end
    else if (m_ctrl[0] && we && ws == 3'd2 && wd[0] && !m_brk) begin e_push = 1; e_dat = 9'h100; end
    else if (!m_ctrl[0] && ev) begin e_push = 1; e_dat = {1'b0, ed}; end
    // R3 R10 line mapping
    chk("R3", {26'd0, irq_o}, {26'd0, exp_lines(m_raw, m_mask)});
    // R1 read mux (R9 covers writes to read-only selects)
    chk("R1", {16'd0, rd_data}, {16'd0, exp_rd(rs)});
    // R8 receive push
    chk("R8", {22'd0, rxq_push, rxq_data & {9{rxq_push}}}, {22'd0, e_push, e_dat});
    @(posedge clk);
    // model update (R2 R4 R5 R6 R7)
    if (we && ws == 3'd6) m_raw = m_raw & ~wd[10:0];
    if (rset) m_raw[4] = 1'b1; else if (rclr) m_raw[4] = 1'b0;
    if (we && ws == 3'd0) m_raw[5] = 1'b1;
    if (rt) m_raw[6] = 1'b1;
    m_raw[10:7] = m_raw[10:7] | es;
    if (we && ws == 3'd1 && wd[0]) begin
      m_flags = {wd[1], wd[3], wd[2], wd[4]};
      m_raw[3:0] = m_flags;
    end
    if (we && ws == 3'd1) m_ctrl = wd[4:0];
    if (we && ws == 3'd2) m_brk = wd[0];
    if (we && ws == 3'd3) m_mask = wd[10:0];
  endtask

  task automatic wr(input logic [2:0] ws, input logic [15:0] wd, input logic [2:0] rs);
    step(1'b1, ws, wd, rs, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 8'd0);
  endtask

  task automatic rd(input logic [2:0] rs);
    step(1'b0, 3'd0, 16'd0, rs, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 8'd0);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    rx_trig_set = 0; rx_trig_clr = 0; rt_set = 0; err_set = 0;
    ext_rx_valid = 0; ext_rx_data = 0;
    m_raw = 0; m_mask = 0; m_ctrl = 0; m_brk = 0; m_flags = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9 reset state
    for (int s = 0; s < 8; s++) rd(3'(s));

    // R4 data write sets TX; R8 no push with loopback off
    wr(3'd3, 16'h07FF, 3'd4);
    wr(3'd0, 16'h0041, 3'd4);
    rd(3'd4);
    chk("R4", {21'd0, rd_data[10:0]}, {21'd0, 11'h020});
    // R9 writes to raw, masked, flag selects
    wr(3'd4, 16'h07FF, 3'd4);
    wr(3'd5, 16'h07FF, 3'd4);
    wr(3'd7, 16'h000F, 3'd7);
    rd(3'd4);
    chk("R9", {21'd0, rd_data[10:0]}, {21'd0, 11'h020});
    // R2 clear and set same cycle: set wins
    step(1'b1, 3'd6, 16'h07FF, 3'd4, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 8'd0);
    rd(3'd4);
    chk("R2", {21'd0, rd_data[10:0]}, {21'd0, 11'h010});
    // R5 set and clear both: set wins, then clear alone
    step(1'b0, 3'd0, 16'd0, 3'd4, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 8'd0);
    rd(3'd4);
    chk("R5", {21'd0, rd_data[10:0]}, {21'd0, 11'h7D0});
    step(1'b0, 3'd0, 16'd0, 3'd4, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 8'd0);
    // R6 loopback entry from a write of only the loopback bit
    wr(3'd1, 16'h0001, 3'd7);
    rd(3'd7);
    chk("R6", {28'd0, rd_data[3:0]}, 32'd0);
    wr(3'd1, 16'h001F, 3'd7);
    rd(3'd7);
    chk("R6", {28'd0, rd_data[3:0]}, 32'hF);
    // R7 group rewrite: only RTS kept -> CTS bit only
    wr(3'd1, 16'h0005, 3'd4);
    rd(3'd4);
    chk("R7", {28'd0, rd_data[3:0]}, 32'h2);
    // R6 write with loopback 0 keeps flags
    wr(3'd1, 16'h001E, 3'd7);
    rd(3'd7);
    chk("R6", {28'd0, rd_data[3:0]}, 32'h2);
    // R8 loopback: break push, ext ignored
    wr(3'd1, 16'h0001, 3'd0);
    wr(3'd2, 16'h0001, 3'd2);
    wr(3'd2, 16'h0001, 3'd2);
    step(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 8'h5A);
    chk("R8", {31'd0, rxq_push}, 32'd0);
    wr(3'd0, 16'h00C3, 3'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (($urandom % 4) == 0) d[0] = ~m_ctrl[0];
      step(1'($urandom % 2), 3'($urandom), d, 3'($urandom),
           1'(($urandom % 5) == 0), 1'(($urandom % 5) == 0),
           1'(($urandom % 6) == 0), 4'($urandom) & 4'($urandom),
           1'($urandom), 8'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule